// File: doc/BRIEF.md
# Two-Way Page Translation Cache

This block holds recently used virtual-to-physical page mappings so that an address can be translated without a page-table access. A 40-bit virtual address splits into a 14-bit page offset (16 KB pages) and a 26-bit virtual page number. The low 8 bits of the page number select one of 256 sets. The upper 18 bits are compared against the tags stored in the two ways of that set. Each entry stores a 22-bit physical page number and a 2-bit rights field. It also keeps valid, dirty and recency flags. A lookup accepted on one clock edge produces its response on the next edge. That response carries the 36-bit physical address, the rights, the dirty state, and exactly one of hit, miss or protection fault.

On a miss, an external table walker supplies the missing mapping through a separate fill channel. The block places the mapping in an empty way of the set if one exists. Otherwise it replaces the way used less recently. A write lookup that hits marks the entry dirty, so that system software can later decide whether the page must be written back. A single invalidate pulse empties the whole structure.

The lookup request and response channels use valid/ready. A request is taken only while no response is waiting, or while the waiting response is consumed in the same cycle. A response held by a low `rsp_ready` stays frozen. The fill channel is valid/ready as well, and it yields to lookups: it is refused in any cycle in which a lookup is accepted. Both channels are refused while `inv_all` is high.

Top module: `tlb_2way`

## Requirements
- R1: A lookup hits only when the selected set (`req_va[21:14]`) holds a valid entry whose tag equals `req_va[39:22]`. The returned physical address is that entry's page number placed above the unchanged offset `req_va[13:0]`.
- R2: A lookup accepted on a clock edge raises `rsp_valid` after that edge, with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. `req_ready` equals `!inv_all && (!rsp_valid || rsp_ready)`. While `rsp_valid && !rsp_ready`, every response field stays unchanged.
- R3: A miss returns `rsp_pa`, `rsp_rights` and `rsp_dirty` all zero, and it changes no stored state.
- R4: A fill of a page number that is not present goes to way 0 of its set if way 0 is invalid, otherwise to way 1 if way 1 is invalid.
- R5: When both ways are valid, a fill of a new page number replaces the way that was not the most recent one to be hit or filled in that set.
- R6: A write lookup that hits sets that entry's dirty flag and reports `rsp_dirty`=1. A read hit reports the current dirty flag. A fill leaves the filled entry clean.
- R7: Bit 0 of the rights field grants write permission. A write lookup that matches an entry with bit 0 clear returns `rsp_fault` (not `rsp_hit`), with the entry's rights, `rsp_pa` zero and the current dirty flag. It changes neither the dirty flag nor the recency.
- R8: After reset, and after any cycle with `inv_all` high, every entry is invalid, so the next lookups miss. While `inv_all` is high, both `req_ready` and `fill_ready` are low.
- R9: A fill whose page number already matches a valid way overwrites that way's page number and rights. It does not occupy the other way.
- R10: `fill_ready` is low in every cycle in which a lookup is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | 40 | Virtual address to translate |
| req_write | input | 1 | Lookup is for a store access |
| rsp_valid | output | 1 | Lookup response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_fault | output | 1 | Write to an entry without write permission |
| rsp_pa | output | 36 | Physical address on a hit, else zero |
| rsp_rights | output | 2 | Rights of the matched entry, else zero |
| rsp_dirty | output | 1 | Dirty flag of the matched entry after the access |
| fill_valid | input | 1 | Fill mapping present |
| fill_ready | output | 1 | Fill can be taken |
| fill_vpn | input | 26 | Virtual page number of the fill |
| fill_ppn | input | 22 | Physical page number of the fill |
| fill_rights | input | 2 | Rights of the fill (bit 0 = writable) |
| inv_all | input | 1 | Invalidate every entry |

## Verification
A corrupted recency flag is invisible until a third page number is filled into an already full set. The wrong resident is then evicted, and this shows up as a miss on the next lookup of the page that should have stayed and as a hit on the page that should have gone. A dirty flag that is set or lost wrongly shows up on the very next hit to that entry, in `rsp_dirty`. A missed valid clear after invalidate or reset shows as a hit one cycle after the next accepted lookup. The stimulus therefore concentrates on a few sets and a few tags, so that fills, evictions and re-hits of the same entries follow closely on one another.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Position of the write-permission bit inside the rights field.
  localparam int WR_BIT = 0;

  typedef enum logic [1:0] {
    LK_MISS  = 2'd0,
    LK_HIT   = 2'd1,
    LK_FAULT = 2'd2
  } lk_kind_e;

endpackage

// File: rtl/tlb_way_store.sv
// One way of the translation cache: per-set flags with reset, payload without.
module tlb_way_store #(
  parameter int SET_W = 8,
  parameter int TAG_W = 18,
  parameter int PPN_W = 22,
  parameter int RT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic [SET_W-1:0] set_i,
  output logic             rd_vld,
  output logic             rd_dirty,
  output logic             rd_ref,
  output logic [RT_W-1:0]  rd_rights,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic             fill_we,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [RT_W-1:0]  fill_rights,
  input  logic             ref_we,
  input  logic             ref_val,
  input  logic             dirty_we
);

  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  ref_q;
  logic [SETS-1:0]  dty_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PPN_W-1:0] ppn_q [SETS];
  logic [RT_W-1:0]  rt_q  [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ref_q <= '0;
      dty_q <= '0;
    end else if (clr_all) begin
      vld_q <= '0;
      ref_q <= '0;
      dty_q <= '0;
    end else begin
      if (fill_we) begin
        vld_q[set_i] <= 1'b1;
        dty_q[set_i] <= 1'b0;
      end
      if (dirty_we) dty_q[set_i] <= 1'b1;
      if (ref_we)   ref_q[set_i] <= ref_val;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[set_i] <= fill_tag;
      ppn_q[set_i] <= fill_ppn;
      rt_q[set_i]  <= fill_rights;
    end
  end

  assign rd_vld    = vld_q[set_i];
  assign rd_dirty  = dty_q[set_i];
  assign rd_ref    = ref_q[set_i];
  assign rd_rights = rt_q[set_i];
  assign rd_tag    = tag_q[set_i];
  assign rd_ppn    = ppn_q[set_i];

endmodule

// File: rtl/tlb_victim.sv
// Replacement choice for a two-way set: empty way first, else the older way.
module tlb_victim (
  input  logic [1:0] vld,
  input  logic [1:0] refb,
  output logic       way
);

  always_comb begin
    if (!vld[0])      way = 1'b0;
    else if (!vld[1]) way = 1'b1;
    else              way = refb[0];  // way 0 most recent -> replace way 1
  end

endmodule

// File: rtl/tlb_2way.sv
module tlb_2way #(
  parameter int VA_W   = 40,
  parameter int PA_W   = 36,
  parameter int PAGE_W = 14,
  parameter int SET_W  = 8,
  parameter int RT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [RT_W-1:0]   rsp_rights,
  output logic              rsp_dirty,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VA_W-PAGE_W-1:0] fill_vpn,
  input  logic [PA_W-PAGE_W-1:0] fill_ppn,
  input  logic [RT_W-1:0]   fill_rights,
  input  logic              inv_all
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - PAGE_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int PPN_W = PA_W - PAGE_W;
  localparam int WAYS  = 2;

  // Channel arbitration: invalidate blocks all, lookups beat fills.
  logic req_fire, fill_fire;
  assign req_ready  = !inv_all && (!rsp_valid || rsp_ready);
  assign req_fire   = req_valid && req_ready;
  assign fill_ready = !inv_all && !req_fire;
  assign fill_fire  = fill_valid && fill_ready;

  // Single access set per cycle, shared by lookup and fill.
  logic [VPN_W-1:0] req_vpn;
  logic [SET_W-1:0] acc_set;
  logic [TAG_W-1:0] acc_tag;
  assign req_vpn = req_va[VA_W-1:PAGE_W];
  assign acc_set = req_fire ? req_vpn[SET_W-1:0]     : fill_vpn[SET_W-1:0];
  assign acc_tag = req_fire ? req_vpn[VPN_W-1:SET_W] : fill_vpn[VPN_W-1:SET_W];

  logic [WAYS-1:0]  w_vld, w_dty, w_ref, w_match;
  logic [WAYS-1:0]  w_fill_we, w_ref_val, w_dirty_we;
  logic [RT_W-1:0]  w_rt  [WAYS];
  logic [TAG_W-1:0] w_tag [WAYS];
  logic [PPN_W-1:0] w_ppn [WAYS];
  logic             touch;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      tlb_way_store #(
        .SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W), .RT_W(RT_W)
      ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (inv_all),
        .set_i      (acc_set),
        .rd_vld     (w_vld[w]),
        .rd_dirty   (w_dty[w]),
        .rd_ref     (w_ref[w]),
        .rd_rights  (w_rt[w]),
        .rd_tag     (w_tag[w]),
        .rd_ppn     (w_ppn[w]),
        .fill_we    (w_fill_we[w]),
        .fill_tag   (acc_tag),
        .fill_ppn   (fill_ppn),
        .fill_rights(fill_rights),
        .ref_we     (touch),
        .ref_val    (w_ref_val[w]),
        .dirty_we   (w_dirty_we[w])
      );
      assign w_match[w] = w_vld[w] && (w_tag[w] == acc_tag);
    end
  endgenerate

  // Tag compare outcome; fills keep at most one matching way per set.
  logic     hit_way, any_match, wr_allowed, victim, fill_way, mru_way;
  lk_kind_e lk_kind;

  assign hit_way    = w_match[1];
  assign any_match  = |w_match;
  assign wr_allowed = !req_write || w_rt[hit_way][WR_BIT];

  always_comb begin
    if (!any_match)      lk_kind = LK_MISS;
    else if (wr_allowed) lk_kind = LK_HIT;
    else                 lk_kind = LK_FAULT;
  end

  tlb_victim u_victim (
    .vld (w_vld),
    .refb(w_ref),
    .way (victim)
  );

  logic lk_hit;
  assign lk_hit   = req_fire && (lk_kind == LK_HIT);
  assign fill_way = any_match ? hit_way : victim;
  assign touch    = lk_hit || fill_fire;
  assign mru_way  = lk_hit ? hit_way : fill_way;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_upd
      assign w_ref_val[w]  = (mru_way == 1'(w));
      assign w_fill_we[w]  = fill_fire && (fill_way == 1'(w));
      assign w_dirty_we[w] = lk_hit && req_write && (hit_way == 1'(w));
    end
  endgenerate

  // Response register with hold under back-pressure.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_pa     <= '0;
      rsp_rights <= '0;
      rsp_dirty  <= 1'b0;
    end else if (req_fire) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= (lk_kind == LK_HIT);
      rsp_miss   <= (lk_kind == LK_MISS);
      rsp_fault  <= (lk_kind == LK_FAULT);
      rsp_pa     <= (lk_kind == LK_HIT) ? {w_ppn[hit_way], req_va[PAGE_W-1:0]} : '0;
      rsp_rights <= any_match ? w_rt[hit_way] : '0;
      rsp_dirty  <= any_match && (w_dty[hit_way] || (lk_kind == LK_HIT && req_write));
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/tlb_2way_chk.sv
module tlb_2way_chk #(
  parameter int VA_W   = 40,
  parameter int PA_W   = 36,
  parameter int PAGE_W = 14,
  parameter int SET_W  = 8,
  parameter int RT_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_va,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_fault,
  input logic [PA_W-1:0]   rsp_pa,
  input logic [RT_W-1:0]   rsp_rights,
  input logic              rsp_dirty,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [VA_W-PAGE_W-1:0] fill_vpn,
  input logic [PA_W-PAGE_W-1:0] fill_ppn,
  input logic [RT_W-1:0]   fill_rights,
  input logic              inv_all
);
  import tlb_pkg::*;

  logic [PAGE_W-1:0] last_off;
  logic              last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_off <= '0;
      last_wr  <= 1'b0;
    end else if (req_valid && req_ready) begin
      last_off <= req_va[PAGE_W-1:0];
      last_wr  <= req_write;
    end
  end

  p_pa_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_pa[PAGE_W-1:0] == last_off);

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)
      && $stable(rsp_miss) && $stable(rsp_fault) && $stable(rsp_rights) && $stable(rsp_dirty));

  p_miss_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> rsp_pa == '0 && rsp_rights == '0 && !rsp_dirty);

  p_write_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && last_wr |-> rsp_dirty);

  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> last_wr && !rsp_rights[WR_BIT] && rsp_pa == '0);

  p_inv_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> !req_ready && !fill_ready);

  p_inv_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_all) && req_valid && req_ready |=> rsp_miss);

  p_lookup_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> !fill_ready);

endmodule

bind tlb_2way tlb_2way_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .SET_W(SET_W), .RT_W(RT_W)
) u_chk (.*);

// File: tb/tb_tlb_2way.sv
module tb_tlb_2way;

  localparam int CLK_PERIOD = 10;
  localparam int VA_W   = 40;
  localparam int PA_W   = 36;
  localparam int PAGE_W = 14;
  localparam int SET_W  = 8;
  localparam int RT_W   = 2;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int TAG_W  = VPN_W - SET_W;
  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int SETS   = 1 << SET_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [VA_W-1:0] req_va = '0;
  logic fill_valid = 1'b0, inv_all = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [RT_W-1:0]  fill_rights = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, fill_ready;
  logic [PA_W-1:0] rsp_pa;
  logic [RT_W-1:0] rsp_rights;

  tlb_2way dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  // Reference state built from the requirements.
  logic             m_vld [SETS][2];
  logic             m_dty [SETS][2];
  logic [TAG_W-1:0] m_tag [SETS][2];
  logic [PPN_W-1:0] m_ppn [SETS][2];
  logic [RT_W-1:0]  m_rt  [SETS][2];
  logic             m_mru [SETS];

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      m_mru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_vld[s][w] = 1'b0;
        m_dty[s][w] = 1'b0;
      end
    end
  endtask

  function automatic int model_find(logic [SET_W-1:0] s, logic [TAG_W-1:0] t);
    for (int w = 0; w < 2; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  // Expected response vector: {hit, miss, fault, dirty, rights, pa}
  task automatic model_lookup(input logic [VA_W-1:0] va, input logic wr,
                              output logic [PA_W+RT_W+3:0] exp);
    logic [SET_W-1:0] s;
    logic [TAG_W-1:0] t;
    int w;
    s = va[PAGE_W+SET_W-1:PAGE_W];
    t = va[VA_W-1:PAGE_W+SET_W];
    w = model_find(s, t);
    if (w < 0) begin
      exp = {1'b0, 1'b1, 1'b0, 1'b0, {RT_W{1'b0}}, {PA_W{1'b0}}};
    end else if (wr && !m_rt[s][w][0]) begin
      exp = {1'b0, 1'b0, 1'b1, m_dty[s][w], m_rt[s][w], {PA_W{1'b0}}};
    end else begin
      if (wr) m_dty[s][w] = 1'b1;
      m_mru[s] = w[0];
      exp = {1'b1, 1'b0, 1'b0, m_dty[s][w], m_rt[s][w], m_ppn[s][w], va[PAGE_W-1:0]};
    end
  endtask

  task automatic model_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                            input logic [RT_W-1:0] rt);
    logic [SET_W-1:0] s;
    logic [TAG_W-1:0] t;
    int w;
    s = vpn[SET_W-1:0];
    t = vpn[VPN_W-1:SET_W];
    w = model_find(s, t);
    if (w < 0) begin
      if (!m_vld[s][0])      w = 0;
      else if (!m_vld[s][1]) w = 1;
      else                   w = m_mru[s] ? 0 : 1;
    end
    m_vld[s][w] = 1'b1;
    m_dty[s][w] = 1'b0;
    m_tag[s][w] = t;
    m_ppn[s][w] = ppn;
    m_rt[s][w]  = rt;
    m_mru[s]    = w[0];
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] mk_va(logic [TAG_W-1:0] t, logic [SET_W-1:0] s,
                                            logic [PAGE_W-1:0] o);
    return {t, s, o};
  endfunction

  function automatic logic [PA_W+RT_W+3:0] rsp_vec();
    return {rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_rights, rsp_pa};
  endfunction

  task automatic do_lookup(input string req, input logic [VA_W-1:0] va, input logic wr);
    logic [PA_W+RT_W+3:0] exp;
    model_lookup(va, wr, exp);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, 64'(rsp_valid), 64'd1);
    check(req, 64'(rsp_vec()), 64'(exp));
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                         input logic [RT_W-1:0] rt);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rights = rt;
    while (!fill_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    model_fill(vpn, ppn, rt);
  endtask

  task automatic do_inv();
    @(negedge clk);
    inv_all = 1'b1;
    #1;
    check("R8 ready low during invalidate", 64'({req_ready, fill_ready}), 64'd0);
    @(negedge clk);
    inv_all = 1'b0;
    model_clear();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    finish_run();
  end

  localparam logic [TAG_W-1:0] TA = 18'h00A5;
  localparam logic [TAG_W-1:0] TB = 18'h3FFFF;
  localparam logic [TAG_W-1:0] TC = 18'h1234;
  localparam logic [SET_W-1:0] S5 = 8'd5;

  initial begin
    logic [PA_W+RT_W+3:0] exp;
    logic [PA_W+RT_W+3:0] held;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R2 reset rsp_valid low", 64'(rsp_valid), 64'd0);
    check("R8 reset ready high", 64'({req_ready, fill_ready}), 64'd3);
    do_lookup("R8 empty after reset", mk_va(TA, S5, 14'h0123), 1'b0);
    do_lookup("R3 miss on empty", mk_va(TB, 8'd255, 14'h3FFF), 1'b1);

    // R4 first fill into way 0, second into way 1; R1 tag compare and address
    do_fill({TA, S5}, 22'h2AAAA, 2'b11);
    do_lookup("R1 hit after fill", mk_va(TA, S5, 14'h1ABC), 1'b0);
    do_lookup("R1 other tag same set misses", mk_va(TB, S5, 14'h0001), 1'b0);
    do_lookup("R1 same tag other set misses", mk_va(TA, 8'd6, 14'h0001), 1'b0);
    do_fill({TB, S5}, 22'h15555, 2'b11);
    do_lookup("R4 second way hit", mk_va(TB, S5, 14'h0002), 1'b0);
    do_lookup("R4 first way kept", mk_va(TA, S5, 14'h3FFF), 1'b0);

    // R5 way A just used, so C replaces B
    do_fill({TC, S5}, 22'h00042, 2'b01);
    do_lookup("R5 older way evicted", mk_va(TB, S5, 14'h0), 1'b0);
    do_lookup("R5 recent way kept", mk_va(TA, S5, 14'h0), 1'b0);
    do_lookup("R5 new entry present", mk_va(TC, S5, 14'h7), 1'b0);

    // R6 dirty marking
    do_lookup("R6 read hit clean", mk_va(TA, S5, 14'h10), 1'b0);
    do_lookup("R6 write hit sets dirty", mk_va(TA, S5, 14'h11), 1'b1);
    do_lookup("R6 read reports dirty", mk_va(TA, S5, 14'h12), 1'b0);

    // R7 write to read-only entry faults, dirty and recency untouched
    do_fill({TB, 8'd9}, 22'h3C3C3, 2'b10);
    do_lookup("R7 write to read-only faults", mk_va(TB, 8'd9, 14'h5), 1'b1);
    do_lookup("R7 read after fault clean", mk_va(TB, 8'd9, 14'h6), 1'b0);
    do_fill({TC, 8'd9}, 22'h00111, 2'b11);
    do_lookup("R7 fault gave no recency", mk_va(TC, 8'd9, 14'h6), 1'b1);
    do_lookup("R7 fault gave no recency", mk_va(TB, 8'd9, 14'h5), 1'b1);
    do_fill({TA, 8'd9}, 22'h00222, 2'b11);
    do_lookup("R5 read-only way replaced by LRU", mk_va(TC, 8'd9, 14'h1), 1'b0);

    // R9 refill of a present page number overwrites in place
    do_fill({TA, S5}, 22'h0BEEF, 2'b01);
    do_lookup("R9 refill overwrites, clears dirty", mk_va(TA, S5, 14'h20), 1'b0);
    do_lookup("R9 other way untouched", mk_va(TC, S5, 14'h21), 1'b0);

    // R10 fill waits while a lookup is accepted
    model_lookup(mk_va(TC, S5, 14'h33), 1'b0, exp);
    @(negedge clk);
    req_valid = 1'b1; req_va = mk_va(TC, S5, 14'h33); req_write = 1'b0;
    fill_valid = 1'b1; fill_vpn = {TB, 8'd77}; fill_ppn = 22'h01234; fill_rights = 2'b11;
    #1;
    check("R10 fill refused during lookup", 64'(fill_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 lookup served first", 64'(rsp_vec()), 64'(exp));
    #1;
    check("R10 fill ready once lookup gone", 64'(fill_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    model_fill({TB, 8'd77}, 22'h01234, 2'b11);
    do_lookup("R10 delayed fill landed", mk_va(TB, 8'd77, 14'h44), 1'b0);

    // R2 back-pressure holds the response
    model_lookup(mk_va(TA, S5, 14'h55), 1'b0, exp);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_va = mk_va(TA, S5, 14'h55); req_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_va = mk_va(TC, S5, 14'h66);
    check("R2 response present", 64'(rsp_vec()), 64'(exp));
    check("R2 ready low while stalled", 64'(req_ready), 64'd0);
    held = rsp_vec();
    @(negedge clk);
    check("R2 response held", 64'({rsp_valid, rsp_vec()}), 64'({1'b1, held}));
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R2 response consumed", 64'(rsp_valid), 64'd0);

    // R8 invalidate everything
    do_inv();
    do_lookup("R8 miss after invalidate", mk_va(TA, S5, 14'h0), 1'b0);
    do_lookup("R8 miss after invalidate", mk_va(TB, 8'd77, 14'h0), 1'b0);

    // Random mix concentrated on few sets and tags
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 1500; i++) begin
      logic [SET_W-1:0] s;
      logic [TAG_W-1:0] t;
      int op;
      case ($urandom % 4)
        0: s = 8'd0;
        1: s = 8'd1;
        2: s = 8'd255;
        default: s = 8'd128;
      endcase
      case ($urandom % 3)
        0: t = TA;
        1: t = TB;
        default: t = TC;
      endcase
      op = int'($urandom % 40);
      if (op < 22)
        do_lookup("R1 R5 R6 R7 random lookup", mk_va(t, s, 14'($urandom)), 1'($urandom));
      else if (op < 39)
        do_fill({t, s}, 22'($urandom), 2'($urandom));
      else
        do_inv();
    end

    finish_run();
  end

endmodule